// File: doc/BRIEF.md
# Prefetch Fault Controller

This block sits at the end of the memory pipeline. It decides what a cache-line prefetch instruction does once its address has been translated. Each accepted strobe carries five things: the instruction form (faulting or non-faulting), an optional base-register post-increment, the base register index with the bounds of the current register stack frame, whether the address lies in the implemented space, and an exception-deferral bit. One clock later the block produces up to three results. It can issue a prefetch request that carries the locality hint and the address, a base-register writeback, and a fault report.

The block handles the prefetch and the base update as two separate results. A prefetch can be dropped or faulted while the post-increment still completes. The deferral bit lets a handler resume a faulting prefetch with the prefetch skipped. A bad base register, meaning register 0 or one outside the frame, raises an ordinary illegal-operation fault. That fault outranks every prefetch outcome. Address translation, the cache and the fault handler lie outside the block.

Top module: `prefetch_fault_ctl`

## Requirements
- R1: An asynchronous active-low reset clears every output to zero at once, without waiting for a clock edge.
- R2: Each result appears on the outputs in the clock cycle after the strobe is sampled and lasts for exactly that one cycle. A cycle with no strobe produces no prefetch, no writeback and no fault.
- R3: The faulting form with an unimplemented address and the deferral bit at 0 reports fault type 2'b01 (unimplemented data address). It issues no prefetch and performs no writeback.
- R4: The non-faulting form with an unimplemented address reports no fault and issues no prefetch. It still performs the writeback when post-increment is requested.
- R5: The faulting form with the deferral bit at 1 issues no prefetch and reports no fault, whether or not the address is implemented. It performs the writeback when post-increment is requested.
- R6: A fault of type 2'b01 sets the non-access flag to 1 and the 4-bit code to 4'd4. A fault of type 2'b10 leaves both at zero.
- R7: Post-increment requested with base register index 0 raises fault type 2'b10 (illegal operation).
- R8: Post-increment requested with a base index below frame_lo or above frame_hi raises fault type 2'b10. Both bounds are inclusive. Without post-increment the index is never checked.
- R9: The illegal-operation fault outranks every other outcome, including the deferral bit. When it is raised there is no prefetch and no writeback.
- R10: A prefetch is issued when there is no illegal fault, the address is implemented, and the faulting form is not deferred. Its address is the base value before the increment. Its hint is forwarded unchanged: 2'b00 temporal at level 1, 2'b01 non-temporal at level 1, 2'b10 non-temporal at level 2, 2'b11 non-temporal at all levels.
- R11: The writeback value is the base plus the sign-extended 9-bit increment, wrapping at the data width. It goes to the same register index and appears in the same cycle as the prefetch decision.
- R12: The non-faulting form ignores the deferral bit. With an implemented address it still issues its prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: a prefetch instruction is presented |
| in_faulting | input | 1 | 1 = faulting form, 0 = non-faulting form |
| in_postinc | input | 1 | Base register post-increment requested |
| in_base_idx | input | IDX_W | Base register index |
| frame_lo | input | IDX_W | Lowest index of the current stack frame (inclusive) |
| frame_hi | input | IDX_W | Highest index of the current stack frame (inclusive) |
| in_addr_ok | input | 1 | Address lies in the implemented space |
| in_defer | input | 1 | Exception-deferral bit |
| in_hint | input | 2 | Locality hint |
| in_base_val | input | DATA_W | Base register value (prefetch address) |
| in_inc | input | INC_W | Signed post-increment amount |
| pf_req | output | 1 | Prefetch request |
| pf_hint | output | 2 | Hint forwarded with the request |
| pf_addr | output | DATA_W | Prefetch address |
| wb_en | output | 1 | Base register writeback enable |
| wb_idx | output | IDX_W | Register index written back |
| wb_val | output | DATA_W | Incremented base value |
| flt_valid | output | 1 | Fault reported |
| flt_type | output | 2 | 2'b01 unimplemented address, 2'b10 illegal operation |
| flt_na | output | 1 | Non-access flag |
| flt_code | output | 4 | Fault code field |

## Verification
The assertions check four properties on every cycle. Fault markings must agree with the fault type. An illegal fault must exclude both the prefetch and the writeback, and a prefetch must never arrive together with a fault. Results must appear only after a strobe. Beyond those, the assertions follow two input conditions: a post-increment on register 0 and a deferred faulting form. For every issued prefetch they confirm the hint and address against the inputs of the previous cycle. Only the bench scenarios can show the rest: the arithmetic of the increment, including negative values and wrap-around, the inclusive frame bounds, the priority of the illegal fault over an unimplemented address, and the asynchronous clearing in the middle of a result cycle.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int HINT_W = 2;
  localparam int FLT_W  = 2;
  localparam int CODE_W = 4;

  typedef enum logic [FLT_W-1:0] {
    FLT_NONE    = 2'b00,
    FLT_UNIMPL  = 2'b01,
    FLT_ILLEGAL = 2'b10
  } flt_e;

  localparam logic [CODE_W-1:0] PF_FLT_CODE = 4'd4;

  typedef struct packed {
    logic pf;
    logic wb;
    flt_e ft;
  } decide_t;
endpackage

// File: rtl/pfc_frame_chk.sv
module pfc_frame_chk #(
  parameter int IDX_W = 7
) (
  input  logic             postinc,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] lo,
  input  logic [IDX_W-1:0] hi,
  output logic             illegal
);
  logic is_zero;
  logic out_of_frame;

  always_comb begin
    is_zero      = (idx == '0);
    out_of_frame = (idx < lo) || (idx > hi);
    illegal      = postinc && (is_zero || out_of_frame);
  end
endmodule

// File: rtl/pfc_incr.sv
module pfc_incr #(
  parameter int DATA_W = 64,
  parameter int INC_W  = 9
) (
  input  logic [DATA_W-1:0] base,
  input  logic [INC_W-1:0]  inc,
  output logic [DATA_W-1:0] sum
);
  localparam int EXT_W = DATA_W - INC_W;
  logic [DATA_W-1:0] inc_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign inc_ext = {{EXT_W{inc[INC_W-1]}}, inc};
    end else begin : g_trunc
      assign inc_ext = inc[DATA_W-1:0];
    end
  endgenerate

  assign sum = base + inc_ext;
endmodule

// File: rtl/pfc_outcome.sv
module pfc_outcome
  import pfc_pkg::*;
(
  input  logic    faulting,
  input  logic    postinc,
  input  logic    addr_ok,
  input  logic    defer,
  input  logic    illegal,
  output decide_t dec
);
  always_comb begin
    dec.pf = 1'b0;
    dec.wb = 1'b0;
    dec.ft = FLT_NONE;
    if (illegal) begin
      dec.ft = FLT_ILLEGAL;
    end else if (faulting && defer) begin
      dec.wb = postinc;
    end else if (!addr_ok) begin
      if (faulting) begin
        dec.ft = FLT_UNIMPL;
      end else begin
        dec.wb = postinc;
      end
    end else begin
      dec.pf = 1'b1;
      dec.wb = postinc;
    end
  end
endmodule

// File: rtl/prefetch_fault_ctl.sv
module prefetch_fault_ctl
  import pfc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 7,
  parameter int INC_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_faulting,
  input  logic              in_postinc,
  input  logic [IDX_W-1:0]  in_base_idx,
  input  logic [IDX_W-1:0]  frame_lo,
  input  logic [IDX_W-1:0]  frame_hi,
  input  logic              in_addr_ok,
  input  logic              in_defer,
  input  logic [HINT_W-1:0] in_hint,
  input  logic [DATA_W-1:0] in_base_val,
  input  logic [INC_W-1:0]  in_inc,
  output logic              pf_req,
  output logic [HINT_W-1:0] pf_hint,
  output logic [DATA_W-1:0] pf_addr,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_val,
  output logic              flt_valid,
  output logic [FLT_W-1:0]  flt_type,
  output logic              flt_na,
  output logic [CODE_W-1:0] flt_code
);
  logic              illegal;
  logic [DATA_W-1:0] sum;
  decide_t           dec;

  logic              pf_req_d, wb_en_d, flt_valid_d, flt_na_d;
  logic [FLT_W-1:0]  flt_type_d;
  logic [CODE_W-1:0] flt_code_d;
  logic              data_en;

  pfc_frame_chk #(.IDX_W(IDX_W)) u_frame (
    .postinc (in_postinc),
    .idx     (in_base_idx),
    .lo      (frame_lo),
    .hi      (frame_hi),
    .illegal (illegal)
  );

  pfc_incr #(.DATA_W(DATA_W), .INC_W(INC_W)) u_incr (
    .base (in_base_val),
    .inc  (in_inc),
    .sum  (sum)
  );

  pfc_outcome u_outcome (
    .faulting (in_faulting),
    .postinc  (in_postinc),
    .addr_ok  (in_addr_ok),
    .defer    (in_defer),
    .illegal  (illegal),
    .dec      (dec)
  );

  always_comb begin
    data_en     = in_valid;
    pf_req_d    = in_valid && dec.pf;
    wb_en_d     = in_valid && dec.wb;
    flt_valid_d = in_valid && (dec.ft != FLT_NONE);
    flt_type_d  = in_valid ? dec.ft : FLT_NONE;
    flt_na_d    = in_valid && (dec.ft == FLT_UNIMPL);
    flt_code_d  = flt_na_d ? PF_FLT_CODE : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_req    <= 1'b0;
      wb_en     <= 1'b0;
      flt_valid <= 1'b0;
      flt_type  <= FLT_NONE;
      flt_na    <= 1'b0;
      flt_code  <= '0;
    end else begin
      pf_req    <= pf_req_d;
      wb_en     <= wb_en_d;
      flt_valid <= flt_valid_d;
      flt_type  <= flt_type_d;
      flt_na    <= flt_na_d;
      flt_code  <= flt_code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_hint <= '0;
      pf_addr <= '0;
      wb_idx  <= '0;
      wb_val  <= '0;
    end else if (data_en) begin
      pf_hint <= in_hint;
      pf_addr <= in_base_val;
      wb_idx  <= in_base_idx;
      wb_val  <= sum;
    end
  end
endmodule

// File: rtl/pfc_chk.sv
module pfc_chk #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_faulting,
  input logic              in_postinc,
  input logic [IDX_W-1:0]  in_base_idx,
  input logic              in_defer,
  input logic [1:0]        in_hint,
  input logic [DATA_W-1:0] in_base_val,
  input logic              pf_req,
  input logic [1:0]        pf_hint,
  input logic [DATA_W-1:0] pf_addr,
  input logic              wb_en,
  input logic              flt_valid,
  input logic [1:0]        flt_type,
  input logic              flt_na,
  input logic [3:0]        flt_code
);
  // R6
  unimpl_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_type == 2'b01) |-> (flt_na && flt_code == 4'd4));

  // R6
  illegal_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_type == 2'b10) |-> (flt_valid && !flt_na && flt_code == 4'd0));

  // R9
  illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_type == 2'b10) |-> (!pf_req && !wb_en));

  // R3
  pf_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req |-> !flt_valid);

  // R2
  no_strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> !(pf_req || wb_en || flt_valid));

  // R7
  reg_zero_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid && in_postinc && in_base_idx == '0))
      |-> (flt_type == 2'b10));

  // R10
  hint_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && pf_req) |-> (pf_hint == $past(in_hint) && pf_addr == $past(in_base_val)));

  // R5
  defer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && in_valid && in_faulting && in_defer) && flt_type != 2'b10)
      |-> (!pf_req && !flt_valid));
endmodule

bind prefetch_fault_ctl pfc_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_prefetch_fault_ctl.sv
module sim_prefetch_fault_ctl;
  localparam int DATA_W = 64;
  localparam int IDX_W  = 7;
  localparam int INC_W  = 9;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid, in_faulting, in_postinc, in_addr_ok, in_defer;
  logic [IDX_W-1:0]  in_base_idx, frame_lo, frame_hi;
  logic [1:0]        in_hint;
  logic [DATA_W-1:0] in_base_val;
  logic [INC_W-1:0]  in_inc;
  logic              pf_req, wb_en, flt_valid, flt_na;
  logic [1:0]        pf_hint, flt_type;
  logic [DATA_W-1:0] pf_addr, wb_val;
  logic [IDX_W-1:0]  wb_idx;
  logic [3:0]        flt_code;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  prefetch_fault_ctl #(.DATA_W(DATA_W), .IDX_W(IDX_W), .INC_W(INC_W)) u0 (.*);

  typedef struct packed {
    logic             f;
    logic             pi;
    logic [IDX_W-1:0] idx;
    logic             ok;
    logic             d;
    logic [1:0]       hint;
    logic [63:0]      base;
    logic [8:0]       inc;
    logic             epf;
    logic             ewb;
    logic [1:0]       eft;
    logic [7:0]       req;
  } vec_t;

  // frame is [32,40]; fault types: 00 none, 01 unimplemented, 10 illegal
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 7'd33, 1'b1, 1'b0, 2'b00, 64'h1000, 9'd0,    1'b1, 1'b0, 2'b00, 8'd10}, // R10
    '{1'b1, 1'b1, 7'd34, 1'b1, 1'b0, 2'b01, 64'h2000, 9'd64,   1'b1, 1'b1, 2'b00, 8'd11}, // R11
    '{1'b0, 1'b1, 7'd35, 1'b1, 1'b0, 2'b10, 64'h3000, 9'h1F8,  1'b1, 1'b1, 2'b00, 8'd11}, // R11 negative
    '{1'b0, 1'b1, 7'd36, 1'b0, 1'b0, 2'b11, 64'h4000, 9'd16,   1'b0, 1'b1, 2'b00, 8'd4},  // R4
    '{1'b0, 1'b0, 7'd36, 1'b0, 1'b0, 2'b00, 64'h4100, 9'd16,   1'b0, 1'b0, 2'b00, 8'd4},  // R4
    '{1'b1, 1'b1, 7'd37, 1'b0, 1'b0, 2'b01, 64'h5000, 9'd8,    1'b0, 1'b0, 2'b01, 8'd3},  // R3
    '{1'b1, 1'b0, 7'd37, 1'b0, 1'b0, 2'b10, 64'h5100, 9'd8,    1'b0, 1'b0, 2'b01, 8'd6},  // R6
    '{1'b1, 1'b1, 7'd38, 1'b0, 1'b1, 2'b11, 64'h6000, 9'd32,   1'b0, 1'b1, 2'b00, 8'd5},  // R5
    '{1'b1, 1'b1, 7'd38, 1'b1, 1'b1, 2'b00, 64'h6100, 9'd32,   1'b0, 1'b1, 2'b00, 8'd5},  // R5
    '{1'b0, 1'b1, 7'd39, 1'b1, 1'b1, 2'b11, 64'h7000, 9'd4,    1'b1, 1'b1, 2'b00, 8'd12}, // R12
    '{1'b1, 1'b1, 7'd0,  1'b1, 1'b0, 2'b00, 64'h8000, 9'd4,    1'b0, 1'b0, 2'b10, 8'd7},  // R7
    '{1'b1, 1'b1, 7'd31, 1'b1, 1'b1, 2'b01, 64'h9000, 9'd4,    1'b0, 1'b0, 2'b10, 8'd9},  // R9 and R8 below
    '{1'b0, 1'b1, 7'd41, 1'b0, 1'b0, 2'b10, 64'hA000, 9'd4,    1'b0, 1'b0, 2'b10, 8'd8},  // R8 above
    '{1'b1, 1'b0, 7'd0,  1'b1, 1'b0, 2'b10, 64'hB000, 9'd4,    1'b1, 1'b0, 2'b00, 8'd8},  // R8 no check
    '{1'b1, 1'b1, 7'd32, 1'b1, 1'b0, 2'b01, 64'hC000, 9'h0FF,  1'b1, 1'b1, 2'b00, 8'd8},  // R8 lo bound
    '{1'b1, 1'b1, 7'd40, 1'b1, 1'b0, 2'b11, 64'h50,   9'h100,  1'b1, 1'b1, 2'b00, 8'd11}, // R11 wrap
    '{1'b1, 1'b1, 7'd0,  1'b0, 1'b0, 2'b00, 64'hD000, 9'd4,    1'b0, 1'b0, 2'b10, 8'd9}   // R9 over unimpl
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_quiet(input string req);
    chk(req, "pf_req", 64'(pf_req), 64'd0);
    chk(req, "wb_en", 64'(wb_en), 64'd0);
    chk(req, "flt_valid", 64'(flt_valid), 64'd0);
  endtask

  task automatic drive(input vec_t v);
    in_faulting = v.f;  in_postinc = v.pi; in_base_idx = v.idx;
    in_addr_ok  = v.ok; in_defer   = v.d;  in_hint     = v.hint;
    in_base_val = v.base; in_inc   = v.inc;
    in_valid    = 1'b1;
  endtask

  task automatic check_vec(input vec_t v);
    string r;
    logic [63:0] ewv;
    logic        ena;
    r   = $sformatf("R%0d", v.req);
    ewv = v.base + {{55{v.inc[8]}}, v.inc};
    ena = (v.eft == 2'b01);
    chk(r, "pf_req", 64'(pf_req), 64'(v.epf));
    chk(r, "wb_en", 64'(wb_en), 64'(v.ewb));
    chk(r, "flt_valid", 64'(flt_valid), 64'(v.eft != 2'b00));
    chk(r, "flt_type", 64'(flt_type), 64'(v.eft));
    chk(r, "flt_na", 64'(flt_na), 64'(ena));
    chk(r, "flt_code", 64'(flt_code), ena ? 64'd4 : 64'd0);
    if (v.epf) begin
      chk(r, "pf_hint", 64'(pf_hint), 64'(v.hint));
      chk(r, "pf_addr", pf_addr, v.base);
    end
    if (v.ewb) begin
      chk(r, "wb_val", wb_val, ewv);
      chk(r, "wb_idx", 64'(wb_idx), 64'(v.idx));
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_faulting = 1'b0; in_postinc = 1'b0;
    in_base_idx = '0; frame_lo = 7'd32; frame_hi = 7'd40; in_addr_ok = 1'b0;
    in_defer = 1'b0; in_hint = '0; in_base_val = '0; in_inc = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk_quiet("R1");
    chk("R1", "flt_code", 64'(flt_code), 64'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk) drive(VECS[i]);
      @(posedge clk); #1;
      check_vec(VECS[i]);
      @(negedge clk) in_valid = 1'b0;
      @(posedge clk); #1;
      // R2 single-cycle result
      chk_quiet("R2");
    end

    // R2 back-to-back strobes, each result lasts one cycle
    @(negedge clk) drive(VECS[1]);
    @(negedge clk) drive(VECS[5]);
    #1 check_vec(VECS[1]);
    @(negedge clk) in_valid = 1'b0;
    #1 check_vec(VECS[5]);
    @(posedge clk); #1;
    chk_quiet("R2");

    // R1 asynchronous clear during a result cycle
    @(negedge clk) drive(VECS[0]);
    @(posedge clk); #1;
    chk("R1", "pf_req before reset", 64'(pf_req), 64'd1);
    #2 rst_n = 1'b0;
    #1;
    chk_quiet("R1");
    chk("R1", "pf_addr", pf_addr, 64'd0);
    chk("R1", "flt_type", 64'(flt_type), 64'd0);
    @(negedge clk) in_valid = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk_quiet("R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule